// File: doc/BRIEF.md
# Flag-Setting Sixteen-Operation ALU

This block is the combinational data path of a small integer execute stage. A 4-bit opcode selects one of sixteen operations on a destination operand and a source operand. The block returns a 32-bit result, a new set of condition flags (negative, zero, carry, overflow) and a write-enable that says whether the result should go back to the destination register.

Bitwise and arithmetic operations are computed inside the block. Shift and rotate operations are not. For those, the result and carry-out of an external barrel shifter are passed through, so the shift amount rules live in one place outside this block. Compare and test operations change only the flags. For every subtraction-type operation the carry flag uses the "no borrow" convention.

Top module: `flag_alu`

## Requirements
- R1: The opcode picks the operation: 0 AND, 1 XOR, 2 shift-left, 3 logical shift-right, 4 arithmetic shift-right, 5 add-with-carry, 6 subtract-with-carry, 7 rotate-right, 8 test, 9 negate, A compare, B compare-negative, C OR, D multiply, E bit-clear (dest AND NOT src), F move-not (NOT src).
- R2: Add-with-carry returns dest + src + C_in. C_out is the carry out of bit 31. V is set when both addends have the same sign and the sign of the result differs from it.
- R3: Subtract-with-carry returns dest − src − (1 − C_in). C_out is 1 exactly when no borrow occurs. V is set on signed overflow.
- R4: Negate returns 0 − src. V is set only when src is 0x80000000, and C is set only when src is zero.
- R5: Test (8), compare (A) and compare-negative (B) drive wr_en low. All other opcodes drive wr_en high. Compare computes dest − src and compare-negative computes dest + src, with the same C and V rules as the matching arithmetic operation.
- R6: For every opcode, Z is 1 exactly when the 32-bit result is zero, and N equals result bit 31.
- R7: AND, XOR, OR, bit-clear, move-not, test and multiply pass C and V through unchanged from flags_in.
- R8: For shift opcodes (2, 3, 4, 7), the result equals shift_res, C equals shift_carry and V is unchanged.
- R9: Multiply returns the low 32 bits of dest × src.
- R10: The flag buses are encoded as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation select |
| dst_val | input | 32 | Destination (first) operand |
| src_val | input | 32 | Source (second) operand |
| flags_in | input | 4 | Incoming N,Z,C,V |
| shift_res | input | 32 | Result from the external shifter |
| shift_carry | input | 1 | Carry-out from the external shifter |
| result | output | 32 | Operation result |
| flags_out | output | 4 | Updated N,Z,C,V |
| wr_en | output | 1 | Write the result to the destination |

## Verification
The hardest cases to reach are the borrow chain of subtract-with-carry when the incoming carry is clear, and negate at its two singular inputs: zero and the most negative value. A random operand almost never hits these. The stimulus table therefore lists these operand values explicitly, with both states of the incoming carry. Directed tests then check the exact flag patterns expected at these values against fixed hand-derived numbers.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_LSL = 4'h2, OP_LSR = 4'h3,
    OP_ASR = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_ROR = 4'h7,
    OP_TST = 4'h8, OP_NEG = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MUL = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
  localparam int FLAG_W = 4;

  function automatic logic op_is_shift(alu_op_e o);
    return (o == OP_LSL) || (o == OP_LSR) || (o == OP_ASR) || (o == OP_ROR);
  endfunction

  function automatic logic op_is_compare(alu_op_e o);
    return (o == OP_TST) || (o == OP_CMP) || (o == OP_CMN);
  endfunction

  function automatic logic op_is_arith(alu_op_e o);
    return (o == OP_ADC) || (o == OP_SBC) || (o == OP_NEG) ||
           (o == OP_CMP) || (o == OP_CMN);
  endfunction

  function automatic logic op_keeps_cv(alu_op_e o);
    return (o == OP_AND) || (o == OP_EOR) || (o == OP_ORR) || (o == OP_BIC) ||
           (o == OP_MVN) || (o == OP_TST) || (o == OP_MUL);
  endfunction
endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           c_in,
  output logic [W-1:0]   sum,
  output logic           c_out,
  output logic           ovf
);
  localparam int SW = W + 1;

  logic [W-1:0] x, y;
  logic         cy;
  logic [SW-1:0] full;

  // Subtraction is x + ~y + carry, so carry-out means "no borrow".
  always_comb begin
    x  = a;
    y  = b;
    cy = 1'b0;
    unique case (op)
      OP_ADC: begin y = b;  cy = c_in; end
      OP_SBC: begin y = ~b; cy = c_in; end
      OP_CMP: begin y = ~b; cy = 1'b1; end
      OP_CMN: begin y = b;  cy = 1'b0; end
      OP_NEG: begin x = '0; y = ~b; cy = 1'b1; end
      default: begin x = a; y = b; cy = 1'b0; end
    endcase
  end

  assign full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cy};
  assign sum   = full[W-1:0];
  assign c_out = full[W];
  assign ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR:         res = a ^ b;
      OP_ORR:         res = a | b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      OP_MUL:         res = a * b;
      default:        res = '0;
    endcase
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]        op,
  input  logic [W-1:0]      dst_val,
  input  logic [W-1:0]      src_val,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [W-1:0]      shift_res,
  input  logic              shift_carry,
  output logic [W-1:0]      result,
  output logic [FLAG_W-1:0] flags_out,
  output logic              wr_en
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  alu_op_e      op_e;
  logic [W-1:0] add_sum, log_res;
  logic         add_cout, add_ovf;
  logic         sel_shift, sel_arith, sel_cmp;

  assign op_e      = alu_op_e'(op);
  assign sel_shift = op_is_shift(op_e);
  assign sel_arith = op_is_arith(op_e);
  assign sel_cmp   = op_is_compare(op_e);

  flag_alu_adder #(.W(W)) u_adder (
    .op(op_e), .a(dst_val), .b(src_val), .c_in(flags_in[FLAG_C]),
    .sum(add_sum), .c_out(add_cout), .ovf(add_ovf)
  );

  flag_alu_logic #(.W(W)) u_logic (
    .op(op_e), .a(dst_val), .b(src_val), .res(log_res)
  );

  always_comb begin
    if (sel_shift)      result = shift_res;
    else if (sel_arith) result = add_sum;
    else                result = log_res;
  end

  always_comb begin
    flags_out[FLAG_N] = result[W-1];
    flags_out[FLAG_Z] = (result == '0);
    if (sel_shift)      flags_out[FLAG_C] = shift_carry;
    else if (sel_arith) flags_out[FLAG_C] = add_cout;
    else                flags_out[FLAG_C] = flags_in[FLAG_C];
    flags_out[FLAG_V] = sel_arith ? add_ovf : flags_in[FLAG_V];
  end

  assign wr_en = ~sel_cmp;

  // Checks on the assembled outputs against the operand ports.
  always_comb begin
    p_wr_en_r5: assert (wr_en == !((op == 4'h8) || (op == 4'hA) || (op == 4'hB)))
      else $error("wr_en wrong for op %h", op);
    p_zero_flag_r6: assert (flags_out[FLAG_Z] == (result == '0))
      else $error("Z inconsistent with result");
    p_neg_flag_r6: assert (flags_out[FLAG_N] == result[W-1])
      else $error("N inconsistent with result");
    if (op_keeps_cv(op_e)) begin
      p_keep_cv_r7: assert (flags_out[1:0] == flags_in[1:0])
        else $error("C/V disturbed by op %h", op);
    end
    if (sel_shift) begin
      p_shift_pass_r8: assert (result == shift_res && flags_out[FLAG_C] == shift_carry &&
                               flags_out[FLAG_V] == flags_in[FLAG_V])
        else $error("shifter pass-through broken");
    end
    if (op == 4'h9) begin
      p_neg_v_r4: assert (flags_out[FLAG_V] == (src_val == MOST_NEG))
        else $error("negate V wrong");
      p_neg_c_r4: assert (flags_out[FLAG_C] == (src_val == '0))
        else $error("negate C wrong");
    end
  end
endmodule

// File: tb/test_flag_alu.sv
module test_flag_alu;
  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [31:0] dst_val, src_val, shift_res;
  logic [3:0]  flags_in;
  logic        shift_carry;
  logic [31:0] result;
  logic [3:0]  flags_out;
  logic        wr_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  flag_alu i_flag_alu (
    .op(op), .dst_val(dst_val), .src_val(src_val), .flags_in(flags_in),
    .shift_res(shift_res), .shift_carry(shift_carry),
    .result(result), .flags_out(flags_out), .wr_en(wr_en)
  );

  // stimulus: op, dst, src, flags_in(NZCV), shift_res, shift_carry
  localparam int NV = 24;
  localparam logic [104:0] VEC [0:NV-1] = '{
    {4'h0, 32'hF0F0_1234, 32'h0FF0_FFFF, 4'b0011, 32'h0, 1'b0},
    {4'h1, 32'hAAAA_5555, 32'hAAAA_5555, 4'b0010, 32'h0, 1'b0},
    {4'h2, 32'h1, 32'h4, 4'b0001, 32'h8000_0000, 1'b1},
    {4'h3, 32'h5, 32'h1, 4'b0011, 32'h0, 1'b1},
    {4'h4, 32'h8000_0000, 32'h1F, 4'b0000, 32'hFFFF_FFFF, 1'b0},
    {4'h5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 32'h0, 1'b0},
    {4'h5, 32'h7FFF_FFFF, 32'h1, 4'b0000, 32'h0, 1'b0},
    {4'h5, 32'h8000_0000, 32'h8000_0000, 4'b0000, 32'h0, 1'b0},
    {4'h6, 32'h5, 32'h3, 4'b0000, 32'h0, 1'b0},
    {4'h6, 32'h5, 32'h5, 4'b0010, 32'h0, 1'b0},
    {4'h6, 32'h0, 32'h0, 4'b0000, 32'h0, 1'b0},
    {4'h6, 32'h8000_0000, 32'h1, 4'b0010, 32'h0, 1'b0},
    {4'h7, 32'h1, 32'h1, 4'b0001, 32'h8000_0000, 1'b1},
    {4'h8, 32'hFF00, 32'h00FF, 4'b0011, 32'h0, 1'b0},
    {4'h9, 32'h0, 32'h8000_0000, 4'b0000, 32'h0, 1'b0},
    {4'h9, 32'h0, 32'h0, 4'b0000, 32'h0, 1'b0},
    {4'h9, 32'h0, 32'h1, 4'b0011, 32'h0, 1'b0},
    {4'hA, 32'h1, 32'h2, 4'b0000, 32'h0, 1'b0},
    {4'hA, 32'h7, 32'h7, 4'b0000, 32'h0, 1'b0},
    {4'hB, 32'hFFFF_FFFF, 32'h1, 4'b0000, 32'h0, 1'b0},
    {4'hC, 32'h8000_0000, 32'h1, 4'b0001, 32'h0, 1'b0},
    {4'hD, 32'h0001_0001, 32'h0001_0001, 4'b0011, 32'h0, 1'b0},
    {4'hE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b0010, 32'h0, 1'b0},
    {4'hF, 32'h0, 32'h0, 4'b0001, 32'h0, 1'b0}
  };

  function automatic logic [36:0] model(input logic [3:0] o, input logic [31:0] a, b,
                                        input logic [3:0] f, input logic [31:0] sr,
                                        input logic sc);
    logic [31:0] r;
    logic n, z, c, v, we;
    longint us, ss;
    c = f[1]; v = f[0]; r = 0; we = 1;
    case (o)
      4'h0: r = a & b;
      4'h1: r = a ^ b;
      4'hC: r = a | b;
      4'hE: r = a & ~b;
      4'hF: r = ~b;
      4'hD: r = a * b;
      4'h8: begin r = a & b; we = 0; end
      4'h2, 4'h3, 4'h4, 4'h7: begin r = sr; c = sc; end
      4'h5, 4'hB: begin
        us = longint'(a) + longint'(b) + ((o == 4'h5) ? longint'(f[1]) : 0);
        ss = longint'($signed(a)) + longint'($signed(b)) + ((o == 4'h5) ? longint'(f[1]) : 0);
        r = us[31:0]; c = us > 64'sh0_FFFF_FFFF;
        v = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
        we = (o == 4'h5);
      end
      default: begin // 6 SBC, 9 NEG, A CMP
        longint x, bor;
        x   = (o == 4'h9) ? 0 : longint'(a);
        bor = (o == 4'h6) ? longint'(!f[1]) : 0;
        us  = x - longint'(b) - bor;
        ss  = ((o == 4'h9) ? 0 : longint'($signed(a))) - longint'($signed(b)) - bor;
        r = us[31:0]; c = (us >= 0);
        v = (ss > 64'sh7FFF_FFFF) || (ss < -64'sh8000_0000);
        we = (o != 4'hA);
      end
    endcase
    n = r[31]; z = (r == 0);
    return {r, n, z, c, v, we};
  endfunction

  task automatic check(input string req, input logic [31:0] er, input logic [3:0] ef,
                       input logic ew);
    checks++;
    if (result !== er || flags_out !== ef || wr_en !== ew) begin
      fails++;
      $display("FAIL %s op=%h: got res=%h nzcv=%b we=%b, exp res=%h nzcv=%b we=%b",
               req, op, result, flags_out, wr_en, er, ef, ew);
    end
  endtask

  task automatic apply(input logic [104:0] vv);
    @(negedge clk);
    {op, dst_val, src_val, flags_in, shift_res, shift_carry} = vv;
    #2;
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'h5: return "R2";
      4'h6: return "R3";
      4'h9: return "R4";
      4'h8, 4'hA, 4'hB: return "R5";
      4'h2, 4'h3, 4'h4, 4'h7: return "R8";
      4'hD: return "R9";
      4'h0, 4'h1, 4'hC, 4'hE, 4'hF: return "R1/R7";
      default: return "R6";
    endcase
  endfunction

  initial begin
    logic [36:0] e;
    op = 0; dst_val = 0; src_val = 0; flags_in = 0; shift_res = 0; shift_carry = 0;
    repeat (2) @(negedge clk);
    #2;
    // R6 R10: all-zero inputs, AND gives zero result, Z set
    check("R6 idle", 32'h0, 4'b0100, 1'b1);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      e = model(op, dst_val, src_val, flags_in, shift_res, shift_carry);
      check(req_of(op), e[36:5], e[4:1], e[0]);
    end

    // Directed corners with hand-derived values
    apply({4'h9, 32'h0, 32'h8000_0000, 4'b0000, 32'h0, 1'b0});
    check("R4 neg min", 32'h8000_0000, 4'b1001, 1'b1);
    apply({4'h9, 32'h0, 32'h0, 4'b0001, 32'h0, 1'b0});
    check("R4 neg zero", 32'h0, 4'b0110, 1'b1);
    apply({4'h6, 32'h5, 32'h3, 4'b0000, 32'h0, 1'b0});
    check("R3 sbc borrow-in", 32'h1, 4'b0010, 1'b1);
    apply({4'h6, 32'h0, 32'h0, 4'b0000, 32'h0, 1'b0});
    check("R3 sbc underflow", 32'hFFFF_FFFF, 4'b1000, 1'b1);
    apply({4'h5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 32'h0, 1'b0});
    check("R2 adc wrap", 32'h0, 4'b0110, 1'b1);
    apply({4'h5, 32'h7FFF_FFFF, 32'h1, 4'b0000, 32'h0, 1'b0});
    check("R2 adc ovf", 32'h8000_0000, 4'b1001, 1'b1);
    apply({4'hA, 32'h1, 32'h2, 4'b0000, 32'h0, 1'b0});
    check("R5 cmp less", 32'hFFFF_FFFF, 4'b1000, 1'b0);
    apply({4'h8, 32'hF0, 32'h0F, 4'b0011, 32'h0, 1'b0});
    check("R5 tst zero", 32'h0, 4'b0111, 1'b0);
    apply({4'hD, 32'h8000_0001, 32'h3, 4'b0010, 32'h0, 1'b0});
    check("R9 mul low", 32'h8000_0003, 4'b1010, 1'b1);
    apply({4'h7, 32'h0, 32'h0, 4'b0001, 32'h0, 1'b1});
    check("R8 ror pass", 32'h0, 4'b0111, 1'b1);
    apply({4'hE, 32'hFF, 32'h0F, 4'b0001, 32'h0, 1'b0});
    check("R1 R7 bic", 32'hF0, 4'b0001, 1'b1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule